// File: doc/BRIEF.md
# Sector Write Buffer Program Sequencer

This block models, in synchronous logic, the write path of a flash front end organised in 256-byte sectors. A host drives active-low chip enable, output enable and write enable strobes with an 18-bit address and a byte of data. Each completed write strobe loads one byte into a sector-wide holding buffer.

Once loading has started, a quiet period with no new strobe closes the load window by itself. The block then raises `busy` and runs a fixed-length cycle on the latched sector. It first writes all-ones to every byte of the sector. It then writes the buffer contents, using all-ones for any byte that was not loaded.

Array writes leave through a valid/ready stream. The consumer may hold `arr_wready` low for any number of cycles. While `arr_wvalid` is high and `arr_wready` is low, the block keeps `arr_waddr` and `arr_wdata` unchanged. A beat is taken on every clock edge where both are high. Reads go straight to the array through `arr_raddr`/`arr_rdata`, except while busy. During a busy cycle a read returns status: bit 7 holds the complement of the last loaded byte's bit 7, and bit 6 alternates from one read to the next. This lets the host poll for completion.

Top module: `sps_top`

## Requirements
- R1: After reset `busy` is 0, `arr_wvalid` is 0 and `dout` is 0x00.
- R2: A load strobe is the interval in which chip enable and write enable are both low while output enable is high. The address is taken in the first cycle of the strobe, and the data in the first cycle after it ends.
- R3: A write enable pulse while output enable is low, or while chip enable is high, loads nothing and opens no window.
- R4: The window opens on the first accepted load. It closes, and `busy` rises, WIN_TICKS cycles after the end of the last strobe if no new strobe has started in that time.
- R5: Within an open window, the sector is set by address bits 17:8 of the first load. A load to any other sector is dropped.
- R6: Bytes may be loaded in any order. If a byte is loaded more than once, the last value loaded is kept.
- R7: A busy cycle issues 256 array writes of 0xFF to the sector in ascending byte order. It then issues 256 writes in ascending order, carrying the loaded bytes and 0xFF for bytes that were not loaded.
- R8: `busy` stays high for exactly CYC_TICKS cycles when both write passes fit in that time. No array write is offered while `busy` is low.
- R9: While `arr_wvalid` is high and `arr_wready` is low, the write beat stays offered with address and data unchanged.
- R10: A read during busy returns the last loaded byte on bits 5:0, and the inverse of its bit 7 on bit 7.
- R11: Bit 6 of a read during busy is 0 on the first read after the window closes. It inverts after each completed read.
- R12: Load strobes while `busy` is high are ignored.
- R13: A read is chip enable and output enable low with write enable high. Outside busy it returns the array byte at `addr`. With no read active, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 18 | Byte address; 17:8 sector, 7:0 byte |
| din | input | 8 | Load data |
| dout | output | 8 | Read data or busy status |
| busy | output | 1 | Window closed, sector cycle running |
| arr_raddr | output | 18 | Array read address |
| arr_rdata | input | 8 | Array read data |
| arr_wvalid | output | 1 | Array write beat offered |
| arr_wready | input | 1 | Array accepts the beat |
| arr_waddr | output | 18 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The load path is tried with several strobe patterns. A sparse, out-of-order load with one byte repeated separates last-value-wins from first-value-wins, and shows the all-ones fill of unloaded bytes. A mixed-sector window shows whether foreign loads are dropped. Strobes with output enable low, or with chip enable high, show whether inhibited pulses open a window. A staggered strobe, with write enable falling before chip enable and the address and data changing in the middle, separates capture at the start of the strobe from capture at the end. The write stream runs against a ready signal that stalls one cycle in four, which exercises the hold rule. Back-to-back reads during busy separate a toggling bit 6 from a fixed one.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ERASE,
    SEQ_PROG,
    SEQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/sps_strobe.sv
module sps_strobe #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_level,
  output logic              ld_end,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              rd_level,
  output logic              rd_end
);
  logic wr_q, rd_q;

  assign wr_level = ~ce_n & ~we_n & oe_n;
  assign rd_level = ~ce_n & ~oe_n & we_n;
  assign ld_end   = ~wr_level & wr_q;
  assign rd_end   = ~rd_level & rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      ld_addr <= '0;
    end else begin
      wr_q <= wr_level;
      rd_q <= rd_level;
      // address taken when the strobe overlap starts (later falling edge)
      if (wr_level && !wr_q) ld_addr <= addr;
    end
  end
endmodule

// File: rtl/sps_load_window.sv
module sps_load_window #(
  parameter int ADDR_W    = 18,
  parameter int BYTE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WIN_TICKS = 30000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_level,
  input  logic                     ld_end,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        din,
  input  logic                     busy,
  input  logic                     release_i,
  input  logic [BYTE_W-1:0]        rd_idx,
  output logic                     close_o,
  output logic [ADDR_W-BYTE_W-1:0] sector_o,
  output logic [DATA_W-1:0]        last_o,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int SEC_BYTES = 1 << BYTE_W;
  localparam int SEC_W     = ADDR_W - BYTE_W;
  localparam int CW        = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_TICKS - 1);

  logic [DATA_W-1:0]    store [SEC_BYTES];
  logic [SEC_BYTES-1:0] loaded_q;
  logic                 open_q;
  logic [CW-1:0]        quiet_q;
  logic [SEC_W-1:0]     sector_q;
  logic [DATA_W-1:0]    last_q;
  logic                 same_sector;
  logic                 accept;

  assign same_sector = (ld_addr[ADDR_W-1:BYTE_W] == sector_q);
  assign accept      = ld_end & ~busy & (~open_q | same_sector);
  assign close_o     = open_q & ~wr_level & ~ld_end & (quiet_q == WIN_LAST);
  assign sector_o    = sector_q;
  assign last_o      = last_q;
  assign rd_data     = store[rd_idx];
  assign rd_valid    = loaded_q[rd_idx];

  always_ff @(posedge clk) begin
    if (accept) store[ld_addr[BYTE_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= '0;
    end else if (release_i) begin
      loaded_q <= '0;
    end else if (accept) begin
      loaded_q[ld_addr[BYTE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      quiet_q  <= '0;
      sector_q <= '0;
      last_q   <= '0;
    end else begin
      if (accept) begin
        open_q <= 1'b1;
        last_q <= din;
        if (!open_q) sector_q <= ld_addr[ADDR_W-1:BYTE_W];
      end
      if (wr_level || ld_end) begin
        quiet_q <= '0;
      end else if (close_o) begin
        open_q  <= 1'b0;
        quiet_q <= '0;
      end else if (open_q) begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sps_prog_seq.sv
module sps_prog_seq
  import sps_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BYTE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CYC_TICKS = 2000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     close_i,
  input  logic [ADDR_W-BYTE_W-1:0] sector_i,
  input  logic [DATA_W-1:0]        buf_data,
  input  logic                     buf_valid,
  input  logic                     arr_wready,
  output logic [BYTE_W-1:0]        buf_idx,
  output logic                     busy,
  output logic                     release_o,
  output logic                     arr_wvalid,
  output logic [ADDR_W-1:0]        arr_waddr,
  output logic [DATA_W-1:0]        arr_wdata
);
  localparam int CW = $clog2(CYC_TICKS + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_TICKS - 1);
  localparam logic [DATA_W-1:0] BLANK = '1;

  seq_state_e        state_q;
  logic [BYTE_W-1:0] idx_q;
  logic [CW-1:0]     tick_q;
  logic              fire;
  logic              at_end;
  logic              tick_done;

  assign busy       = (state_q != SEQ_IDLE);
  assign arr_wvalid = (state_q == SEQ_ERASE) || (state_q == SEQ_PROG);
  assign arr_waddr  = {sector_i, idx_q};
  assign arr_wdata  = (state_q == SEQ_PROG && buf_valid) ? buf_data : BLANK;
  assign buf_idx    = idx_q;
  assign fire       = arr_wvalid & arr_wready;
  assign at_end     = &idx_q;
  assign tick_done  = (tick_q == CYC_LAST);
  assign release_o  = (state_q == SEQ_HOLD) && tick_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      tick_q  <= '0;
    end else begin
      if (state_q != SEQ_IDLE && !tick_done) tick_q <= tick_q + 1'b1;
      if (fire) idx_q <= idx_q + 1'b1;
      unique case (state_q)
        SEQ_IDLE: begin
          if (close_i) begin
            state_q <= SEQ_ERASE;
            idx_q   <= '0;
            tick_q  <= '0;
          end
        end
        SEQ_ERASE: if (fire && at_end) state_q <= SEQ_PROG;
        SEQ_PROG:  if (fire && at_end) state_q <= SEQ_HOLD;
        SEQ_HOLD:  if (tick_done) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sps_status.sv
module sps_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              close_i,
  input  logic              rd_level,
  input  logic              rd_end,
  input  logic [DATA_W-1:0] last_i,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout
);
  logic toggle_q;
  logic [DATA_W-1:0] status;

  assign status = {~last_i[DATA_W-1], toggle_q, last_i[DATA_W-3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)              toggle_q <= 1'b0;
    else if (close_i)        toggle_q <= 1'b0;
    else if (busy && rd_end) toggle_q <= ~toggle_q;
  end

  always_comb begin
    if (!rd_level)  dout = '0;
    else if (busy)  dout = status;
    else            dout = arr_rdata;
  end
endmodule

// File: rtl/sps_top.sv
module sps_top #(
  parameter int ADDR_W    = 18,
  parameter int BYTE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WIN_TICKS = 30000,
  parameter int CYC_TICKS = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_wvalid,
  input  logic              arr_wready,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int SEC_W = ADDR_W - BYTE_W;

  logic              wr_level, ld_end, rd_level, rd_end;
  logic [ADDR_W-1:0] ld_addr;
  logic              win_close, seq_release;
  logic [SEC_W-1:0]  win_sector;
  logic [DATA_W-1:0] last_data;
  logic [DATA_W-1:0] buf_data;
  logic              buf_valid;
  logic [BYTE_W-1:0] buf_idx;

  assign arr_raddr = addr;

  sps_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wr_level(wr_level), .ld_end(ld_end), .ld_addr(ld_addr),
    .rd_level(rd_level), .rd_end(rd_end)
  );

  sps_load_window #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .WIN_TICKS(WIN_TICKS)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .wr_level(wr_level), .ld_end(ld_end),
    .ld_addr(ld_addr), .din(din), .busy(busy), .release_i(seq_release),
    .rd_idx(buf_idx), .close_o(win_close), .sector_o(win_sector),
    .last_o(last_data), .rd_data(buf_data), .rd_valid(buf_valid)
  );

  sps_prog_seq #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .CYC_TICKS(CYC_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .close_i(win_close), .sector_i(win_sector),
    .buf_data(buf_data), .buf_valid(buf_valid), .arr_wready(arr_wready),
    .buf_idx(buf_idx), .busy(busy), .release_o(seq_release),
    .arr_wvalid(arr_wvalid), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  sps_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .busy(busy), .close_i(win_close),
    .rd_level(rd_level), .rd_end(rd_end), .last_i(last_data),
    .arr_rdata(arr_rdata), .dout(dout)
  );
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dout,
  input logic              busy,
  input logic              arr_wvalid,
  input logic              arr_wready,
  input logic [ADDR_W-1:0] arr_waddr,
  input logic [DATA_W-1:0] arr_wdata,
  input logic [DATA_W-1:0] last_q
);
  // R8
  wvalid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wvalid |-> busy);

  // R8
  busy_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(arr_wvalid));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wvalid && !arr_wready) |=>
      (arr_wvalid && $stable(arr_waddr) && $stable(arr_wdata)));

  // R10
  poll_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce_n && !oe_n && we_n) |-> (dout[DATA_W-1] != last_q[DATA_W-1]));

  // R13
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (dout == '0));

  // R4
  close_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ce_n || we_n || !oe_n));
endmodule

bind sps_top sps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout(dout), .busy(busy), .arr_wvalid(arr_wvalid), .arr_wready(arr_wready),
  .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .last_q(last_data)
);

// File: tb/sps_top_tb.sv
`timescale 1ns/1ps
module sps_top_tb_top;
  localparam int WIN = 40;
  localparam int CYC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, arr_rdata, arr_wdata;
  logic [17:0] arr_raddr, arr_waddr;
  logic        busy, arr_wvalid, arr_wready;

  logic [7:0] tbmem  [1024];
  logic [7:0] refmem [1024];
  int cyc = 0;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign arr_wready = (cyc % 4) != 3;
  assign arr_rdata  = (arr_raddr < 18'd1024) ? tbmem[arr_raddr[9:0]] : 8'hFF;

  sps_top #(.WIN_TICKS(WIN), .CYC_TICKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata), .arr_wvalid(arr_wvalid), .arr_wready(arr_wready),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_wr_q, m_rd_q, m_open, m_busy, m_tog, m_pend;
  int m_quiet, m_bcnt, m_sector, m_wcnt, m_cap;
  int m_last;
  int m_buf [256];
  logic [17:0] p_addr;
  logic [7:0]  p_data;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    bit now, rnow, endw, rend;
    if (!rst_n) begin
      m_wr_q = 0; m_rd_q = 0; m_open = 0; m_busy = 0; m_tog = 0; m_pend = 0;
      m_quiet = 0; m_bcnt = 0; m_sector = 0; m_wcnt = 0; m_cap = 0; m_last = 0;
      for (int i = 0; i < 256; i++) m_buf[i] = -1;
    end else begin
      // R9: a stalled beat must reappear unchanged
      if (m_pend) begin
        chk("R9 hold", {arr_wvalid, arr_waddr, arr_wdata}, {1'b1, p_addr, p_data});
        m_pend = 0;
      end
      if (arr_wvalid && !arr_wready) begin
        m_pend = 1; p_addr = arr_waddr; p_data = arr_wdata;
      end
      if (arr_wvalid && arr_wready) begin
        int bi, ed;
        bi = m_wcnt % 256;
        ed = (m_wcnt < 256 || m_buf[bi] < 0) ? 8'hFF : m_buf[bi];
        chk("R7 waddr", int'(arr_waddr), m_sector * 256 + bi);
        chk("R7 wdata", int'(arr_wdata), ed);
        if (arr_waddr < 18'd1024) tbmem[arr_waddr[9:0]] = arr_wdata;
        m_wcnt++;
      end
      now  = !ce_n && !we_n && oe_n;
      rnow = !ce_n && !oe_n && we_n;
      endw = !now && m_wr_q;
      rend = !rnow && m_rd_q;
      if (m_busy && rend) m_tog = !m_tog;
      if (m_busy) begin
        m_bcnt++;
        if (m_bcnt == CYC) begin
          chk("R7 write count", m_wcnt, 512);
          m_busy = 0;
          for (int i = 0; i < 256; i++) begin
            if (m_sector < 4) refmem[m_sector*256 + i] = (m_buf[i] < 0) ? 8'hFF : m_buf[i][7:0];
            m_buf[i] = -1;
          end
        end
      end else if (endw && (!m_open || (m_cap >> 8) == m_sector)) begin
        if (!m_open) m_sector = m_cap >> 8;
        m_open = 1;
        m_buf[m_cap % 256] = din;
        m_last = din;
      end
      if (now || endw) m_quiet = 0;
      else if (m_open && m_quiet == WIN - 1) begin
        m_open = 0; m_quiet = 0; m_busy = 1; m_bcnt = 0; m_tog = 0; m_wcnt = 0;
      end else if (m_open) m_quiet++;
      if (now && !m_wr_q) m_cap = addr;
      m_wr_q = now;
      m_rd_q = rnow;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] exp_d;
      bit rnow;
      rnow = !ce_n && !oe_n && we_n;
      chk("R4 R8 busy", busy, m_busy);
      if (!rnow) exp_d = 8'h00;
      else if (m_busy) exp_d = {~m_last[7], m_tog, m_last[5:0]};
      else exp_d = (addr < 18'd1024) ? refmem[addr[9:0]] : 8'hFF;
      chk(m_busy ? "R10 R11 status" : "R13 read", dout, exp_d);
    end
  end

  task automatic load(input logic [17:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; we_n = 1'b1;
    @(posedge clk); #1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] v);
    @(posedge clk); #1; addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); v = dout;
    @(posedge clk); #1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_busy(input bit lvl);
    int guard = 0;
    while (busy !== lvl && guard < 5000) begin @(posedge clk); #1; guard++; end
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 1024; i++) begin tbmem[i] = 8'hFF; refmem[i] = 8'hFF; end
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 wvalid", arr_wvalid, 0);
    chk("R1 dout", dout, 0);

    // R6: out of order, repeated byte
    load(18'h105, 8'h11); load(18'h1C8, 8'h42); load(18'h102, 8'h80);
    load(18'h105, 8'h3C); load(18'h1C8, 8'hA5);
    wait_busy(1'b1);
    rd(18'h105, v); chk("R10 first poll", v, 8'h25);
    rd(18'h1C8, v); chk("R11 second poll", v, 8'h65);
    load(18'h107, 8'h00);           // R12: ignored while busy
    wait_busy(1'b0);
    idle(2);
    rd(18'h105, v); chk("R6 last value wins", v, 8'h3C);
    rd(18'h102, v); chk("R6 out of order", v, 8'h80);
    rd(18'h1C8, v); chk("R6 repeat", v, 8'hA5);
    rd(18'h107, v); chk("R12 busy load ignored", v, 8'hFF);
    rd(18'h100, v); chk("R7 unloaded fill", v, 8'hFF);

    // R3: inhibited strobes
    @(posedge clk); #1; addr = 18'h200; din = 8'h11; ce_n = 0; oe_n = 0; we_n = 0;
    idle(2); we_n = 1; idle(1); ce_n = 1; oe_n = 1;
    @(posedge clk); #1; addr = 18'h201; din = 8'h22; ce_n = 1; we_n = 0;
    idle(2); we_n = 1;
    idle(WIN + 10);
    chk("R3 no window", busy, 0);
    rd(18'h200, v); chk("R3 oe low inhibits", v, 8'hFF);
    rd(18'h201, v); chk("R3 ce high inhibits", v, 8'hFF);

    // R5: foreign sector dropped
    load(18'h300, 8'h77); load(18'h205, 8'h99); load(18'h3FF, 8'h42);
    wait_busy(1'b1); wait_busy(1'b0); idle(2);
    rd(18'h300, v); chk("R5 first", v, 8'h77);
    rd(18'h3FF, v); chk("R5 last byte", v, 8'h42);
    rd(18'h205, v); chk("R5 foreign dropped", v, 8'hFF);

    // R2: staggered strobe, address and data moving mid-strobe
    @(posedge clk); #1; addr = 18'h310; din = 8'h01; we_n = 0; oe_n = 1;
    @(posedge clk); #1; addr = 18'h311; ce_n = 0;
    @(posedge clk); #1; addr = 18'h312; din = 8'h5A;
    @(posedge clk); #1; we_n = 1;
    @(posedge clk); #1; ce_n = 1; din = 8'hEE;
    wait_busy(1'b1); wait_busy(1'b0); idle(2);
    rd(18'h311, v); chk("R2 capture", v, 8'h5A);
    rd(18'h312, v); chk("R2 late address", v, 8'hFF);
    rd(18'h300, v); chk("R7 sector re-erased", v, 8'hFF);
    idle(3);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule